// File: doc/BRIEF.md
# Debug Module Register Front-End

This block sits behind the debug transport and serves the register file that an external debugger uses to run-control a set of harts. It accepts one request at a time on a valid/ready request channel carrying a 7-bit register address, a 2-bit operation code and 32 bits of write data. It answers on a valid/ready response channel with 32 bits of read data and a 2-bit result code. Only one transaction is in flight: a new request is refused until the previous response has been taken.

Behind the decode sit four things. The first is the control register, which holds the selected hart number, the non-debug-mode reset bit and the module-active bit. The second is a status word built from the selected hart's halted, running, resume-acknowledge and unavailable inputs. The third is a bank of abstract data words and program buffer words. The last is a per-hart level halt request plus single-cycle resume and reset-acknowledge pulses.

Several optional features are tied off. Every all-harts status bit equals its any-harts partner, unimplemented addresses read zero, and the halt-on-reset request bits do nothing.

Top module: `dbg_regfront`

## Requirements
- R1: A request is accepted on a rising edge where req_valid and req_ready are both 1. rsp_valid is 1 from the next cycle on. req_ready is 0 while a response is pending. rsp_data and rsp_code stay stable until a cycle where rsp_ready is 1.
- R2: The data words at addresses 0x04..0x0f and the program buffer words at 0x20..0x2f reset to 0, and each read returns the last value written to that word.
- R3: A read of any other address, except 0x10 and 0x11, returns 0. A write to such an address changes no readable word.
- R4: Operation code 1 is a read and 2 is a write, and both return result code 0. Code 0 is a no-op that returns data 0 and result code 0. Code 3 returns result code 2 and changes nothing.
- R5: The control register at 0x10 reads back the hart-select low part in bits 25:16, the high part in bits 15:6, the reset bit in bit 1 and the active bit in bit 0. Bits 31, 30, 29, 28 and 26 always read 0.
- R6: Outputs ndm_reset and dm_active follow control bits 1 and 0 from the cycle after the write is accepted.
- R7: A control write with bit 0 set stores the new hart select and writes bit 31 into the level halt request of the selected hart, if that hart exists. Other harts keep their request. When the selected hart does not exist, no halt request changes.
- R8: A control write with bit 0 set and bit 30 (or bit 28) set raises resume_pulse (or ack_pulse) for the selected existing hart for exactly the one cycle after acceptance.
- R9: A control write with bit 0 clear returns every halt request, the hart select and the reset bit to 0.
- R10: The status register at 0x11 has bits 3:0 equal to 2 and bit 7 equal to 1. Bits 22, 19, 18, 6, 5 and 4 read 0.
- R11: For an existing selected hart, status bit pairs 9/8, 11/10, 13/12 and 17/16 both equal that hart's halted, running, unavailable and resume-acknowledge inputs, each input sampled in the cycle the read is accepted.
- R12: For a non-existent selected hart, status bits 15 and 14 are 1 and the halted, running, unavailable and resume-acknowledge pairs are 0.
- R13: Control bits 3 and 2 have no effect: the control and status read-back after such a write equals the read-back without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 7 | Register address |
| req_op | input | 2 | Operation: 0 no-op, 1 read, 2 write |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Read data |
| rsp_code | output | 2 | Result: 0 success, 2 failed |
| hart_halted | input | NUM_HARTS | Per-hart halted status |
| hart_running | input | NUM_HARTS | Per-hart running status |
| hart_resumeack | input | NUM_HARTS | Per-hart resume acknowledge |
| hart_unavail | input | NUM_HARTS | Per-hart unavailable, active high |
| halt_req | output | NUM_HARTS | Level halt request per hart |
| resume_pulse | output | NUM_HARTS | One-cycle resume request per hart |
| ack_pulse | output | NUM_HARTS | One-cycle reset acknowledge per hart |
| ndm_reset | output | 1 | Non-debug-mode reset |
| dm_active | output | 1 | Module active |

## Verification
Random writes and reads over the data and program buffer words are compared with a bench model. This separates per-word storage from address aliasing between the two ranges. The status word is read with random per-hart input patterns and random hart selections, some of which name harts that do not exist. These patterns separate correct hart indexing and the paired all/any bits from the non-existent case. Directed writes cover the remaining cases: control bits that must read 0, the tied-off halt-on-reset bits, pulse width and timing, clearing by the active bit, and a response held back while rsp_ready is low.

// File: rtl/dbg_regfront_pkg.sv
// Shared encodings for the debug register front-end.
// Assumes a 7-bit register address and 32-bit register words.
package dbg_regfront_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } dmi_op_e;

    localparam logic [1:0] RSP_OK   = 2'd0;
    localparam logic [1:0] RSP_FAIL = 2'd2;

    localparam logic [6:0] ADDR_DATA0 = 7'h04;
    localparam logic [6:0] ADDR_CTRL  = 7'h10;
    localparam logic [6:0] ADDR_STAT  = 7'h11;
    localparam logic [6:0] ADDR_PBUF0 = 7'h20;

    localparam int SEL_W = 20;
endpackage

// File: rtl/dbg_ctrl.sv
// Control register: hart select, halt request levels, resume and
// reset-acknowledge pulses, non-debug reset and module-active bits.
// Assumes wr_en is a single-cycle strobe for an accepted write.
module dbg_ctrl
    import dbg_regfront_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [31:0]          wdata,
    output logic [SEL_W-1:0]     hartsel,
    output logic [NUM_HARTS-1:0] halt_req,
    output logic [NUM_HARTS-1:0] resume_pulse,
    output logic [NUM_HARTS-1:0] ack_pulse,
    output logic                 ndm_reset,
    output logic                 dm_active,
    output logic [31:0]          rd_word
);
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    logic [SEL_W-1:0] new_sel;
    logic             new_sel_ok;
    logic [IDX_W-1:0] new_idx;
    logic             unused_ctrl_bits;

    // Decode the hart select carried by the write data.
    always_comb begin
        new_sel    = {wdata[15:6], wdata[25:16]};
        new_sel_ok = new_sel < SEL_W'(NUM_HARTS);
        new_idx    = new_sel[IDX_W-1:0];
    end

    assign unused_ctrl_bits = ^{wdata[29], wdata[27:26], wdata[5:2]};

    // Control state update on accepted writes; pulses last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hartsel      <= '0;
            halt_req     <= '0;
            resume_pulse <= '0;
            ack_pulse    <= '0;
            ndm_reset    <= 1'b0;
            dm_active    <= 1'b0;
        end else begin
            resume_pulse <= '0;
            ack_pulse    <= '0;
            if (wr_en) begin
                if (!wdata[0]) begin
                    hartsel   <= '0;
                    halt_req  <= '0;
                    ndm_reset <= 1'b0;
                    dm_active <= 1'b0;
                end else begin
                    dm_active <= 1'b1;
                    ndm_reset <= wdata[1];
                    hartsel   <= new_sel;
                    if (new_sel_ok) begin
                        halt_req[new_idx]     <= wdata[31];
                        resume_pulse[new_idx] <= wdata[30];
                        ack_pulse[new_idx]    <= wdata[28];
                    end
                end
            end
        end
    end

    // Read-back word; write-only and tied-off fields read zero.
    always_comb begin
        rd_word = {6'b0, hartsel[9:0], hartsel[19:10], 4'b0, ndm_reset, dm_active};
    end

    a_r9_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dm_active |-> (halt_req == '0 && !ndm_reset));
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|resume_pulse) |=> (resume_pulse == '0));
    a_r8_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resume_pulse) && $onehot0(ack_pulse));
endmodule

// File: rtl/dbg_status.sv
// Status word built from the selected hart's inputs; all/any pairs mirror.
// Assumes harts are numbered 0..NUM_HARTS-1 contiguously.
module dbg_status
    import dbg_regfront_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic [SEL_W-1:0]     hartsel,
    input  logic [NUM_HARTS-1:0] hart_halted,
    input  logic [NUM_HARTS-1:0] hart_running,
    input  logic [NUM_HARTS-1:0] hart_resumeack,
    input  logic [NUM_HARTS-1:0] hart_unavail,
    output logic [31:0]          rd_word
);
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    logic             exists;
    logic [IDX_W-1:0] idx;

    // Assemble the status fields for the currently selected hart.
    always_comb begin
        exists       = hartsel < SEL_W'(NUM_HARTS);
        idx          = hartsel[IDX_W-1:0];
        rd_word      = '0;
        rd_word[3:0] = 4'd2;
        rd_word[7]   = 1'b1;
        if (exists) begin
            rd_word[9:8]   = {2{hart_halted[idx]}};
            rd_word[11:10] = {2{hart_running[idx]}};
            rd_word[13:12] = {2{hart_unavail[idx]}};
            rd_word[17:16] = {2{hart_resumeack[idx]}};
        end else begin
            rd_word[15:14] = 2'b11;
        end
    end
endmodule

// File: rtl/dbg_bank.sv
// Abstract data words and program buffer words with address decode.
// Assumes both ranges fit the 7-bit space without overlap.
module dbg_bank
    import dbg_regfront_pkg::*;
#(
    parameter int NUM_DATA = 12,
    parameter int NUM_PROG = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [6:0]  addr,
    input  logic [31:0] wdata,
    output logic        hit,
    output logic [31:0] rd_word
);
    localparam int TOTAL = NUM_DATA + NUM_PROG;

    logic [TOTAL-1:0]       sel;
    logic [TOTAL-1:0][31:0] words;

    for (genvar i = 0; i < TOTAL; i++) begin : g_word
        localparam logic [6:0] WADDR = (i < NUM_DATA) ? ADDR_DATA0 + 7'(i)
                                                      : ADDR_PBUF0 + 7'(i - NUM_DATA);
        assign sel[i] = (addr == WADDR);

        // One storage word, written when its address is hit.
        always_ff @(posedge clk) begin
            if (!rst_n)               words[i] <= '0;
            else if (wr_en && sel[i]) words[i] <= wdata;
        end
    end

    // OR-reduce the selected word onto the read bus.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < TOTAL; i++) begin
            if (sel[i]) rd_word |= words[i];
        end
        hit = |sel;
    end
endmodule

// File: rtl/dbg_regfront.sv
// Register front-end: one outstanding request, registered response.
// Assumes the requester holds its fields stable while req_valid is high.
module dbg_regfront
    import dbg_regfront_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int NUM_DATA  = 12,
    parameter int NUM_PROG  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [6:0]           req_addr,
    input  logic [1:0]           req_op,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [31:0]          rsp_data,
    output logic [1:0]           rsp_code,
    input  logic [NUM_HARTS-1:0] hart_halted,
    input  logic [NUM_HARTS-1:0] hart_running,
    input  logic [NUM_HARTS-1:0] hart_resumeack,
    input  logic [NUM_HARTS-1:0] hart_unavail,
    output logic [NUM_HARTS-1:0] halt_req,
    output logic [NUM_HARTS-1:0] resume_pulse,
    output logic [NUM_HARTS-1:0] ack_pulse,
    output logic                 ndm_reset,
    output logic                 dm_active
);
    logic             accept, is_wr, is_rd;
    logic [SEL_W-1:0] hartsel;
    logic [31:0]      ctrl_word, stat_word, bank_word, rd_mux;
    logic             bank_hit;

    assign req_ready = !rsp_valid;
    assign accept    = req_valid && req_ready;
    assign is_wr     = accept && (req_op == OP_WRITE);
    assign is_rd     = (req_op == OP_READ);

    dbg_ctrl #(.NUM_HARTS(NUM_HARTS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(is_wr && req_addr == ADDR_CTRL), .wdata(req_wdata),
        .hartsel(hartsel), .halt_req(halt_req), .resume_pulse(resume_pulse),
        .ack_pulse(ack_pulse), .ndm_reset(ndm_reset), .dm_active(dm_active),
        .rd_word(ctrl_word)
    );

    dbg_status #(.NUM_HARTS(NUM_HARTS)) u_status (
        .hartsel(hartsel), .hart_halted(hart_halted), .hart_running(hart_running),
        .hart_resumeack(hart_resumeack), .hart_unavail(hart_unavail),
        .rd_word(stat_word)
    );

    dbg_bank #(.NUM_DATA(NUM_DATA), .NUM_PROG(NUM_PROG)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(is_wr), .addr(req_addr),
        .wdata(req_wdata), .hit(bank_hit), .rd_word(bank_word)
    );

    // Read data select; unimplemented addresses and non-reads give zero.
    always_comb begin
        rd_mux = '0;
        if (is_rd) begin
            if (req_addr == ADDR_CTRL)      rd_mux = ctrl_word;
            else if (req_addr == ADDR_STAT) rd_mux = stat_word;
            else if (bank_hit)              rd_mux = bank_word;
        end
    end

    // Response register: loaded on accept, cleared when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_code  <= RSP_OK;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_mux;
            rsp_code  <= (req_op == OP_RSVD) ? RSP_FAIL : RSP_OK;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    a_r1_accept_resp: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_code)));
endmodule

// File: tb/dbg_regfront_bench.sv
module dbg_regfront_bench;
    localparam int NH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, rsp_ready = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, ndm_reset, dm_active;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_code;
    logic [NH-1:0] h_halt = '0, h_run = '0, h_ack = '0, h_unav = '0;
    logic [NH-1:0] halt_req, resume_pulse, ack_pulse;

    int tests = 0, fails = 0, cycles = 0;
    logic [NH-1:0] snap_res1, snap_res2, snap_ack1, snap_ack2;
    logic          snap_valid;
    logic [31:0]   model [0:127];

    always #5 clk = ~clk;

    dbg_regfront #(.NUM_HARTS(NH)) u_dbg_regfront (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_op(req_op), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_code(rsp_code), .hart_halted(h_halt), .hart_running(h_run),
        .hart_resumeack(h_ack), .hart_unavail(h_unav), .halt_req(halt_req),
        .resume_pulse(resume_pulse), .ack_pulse(ack_pulse),
        .ndm_reset(ndm_reset), .dm_active(dm_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [6:0] a, input logic [1:0] op, input logic [31:0] wd,
                        output logic [31:0] rd, output logic [1:0] rc);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_op = op; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        snap_valid = rsp_valid; rd = rsp_data; rc = rsp_code;
        snap_res1 = resume_pulse; snap_ack1 = ack_pulse;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        snap_res2 = resume_pulse; snap_ack2 = ack_pulse;
    endtask

    function automatic logic [31:0] ctrlw(logic h, logic r, logic k, logic [19:0] s,
                                          logic n, logic act);
        return {h, r, 1'b0, k, 2'b00, s[9:0], s[19:10], 4'b0, n, act};
    endfunction

    function automatic logic [31:0] exp_stat(int s, logic [NH-1:0] hh, logic [NH-1:0] rr,
                                             logic [NH-1:0] aa, logic [NH-1:0] uu);
        logic [31:0] w = 32'h0000_0082;
        if (s < NH) begin
            w[9:8] = {2{hh[s]}}; w[11:10] = {2{rr[s]}};
            w[13:12] = {2{uu[s]}}; w[17:16] = {2{aa[s]}};
        end else w[15:14] = 2'b11;
        return w;
    endfunction

    function automatic logic [6:0] rand_word_addr();
        int k = $urandom_range(0, 27);
        return (k < 12) ? 7'(4 + k) : 7'(32 + k - 12);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [1:0]  rc;
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        check("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R6 reset outputs", {30'b0, ndm_reset, dm_active}, 32'd0);
        xfer(7'h04, 2'd1, 0, rd, rc);
        check("R2 reset data0", rd, 0);
        check("R1 response next cycle", {31'b0, snap_valid}, 1);
        xfer(7'h2f, 2'd1, 0, rd, rc);
        check("R2 reset progbuf15", rd, 0);

        // R2 random storage
        for (int i = 0; i < 200; i++) begin
            logic [6:0] a = rand_word_addr();
            if ($urandom_range(0, 1) == 1) begin
                logic [31:0] v = $urandom();
                xfer(a, 2'd2, v, rd, rc);
                model[a] = v;
            end else begin
                xfer(a, 2'd1, 0, rd, rc);
                check("R2 word readback", rd, model[a]);
            end
        end
        for (int a = 4; a < 48; a++) begin
            if (a < 16 || a >= 32) begin
                xfer(7'(a), 2'd1, 0, rd, rc);
                check("R2 sweep readback", rd, model[a]);
            end
        end

        // R3 unimplemented addresses
        xfer(7'h18, 2'd2, 32'hDEAD_BEEF, rd, rc);
        xfer(7'h18, 2'd1, 0, rd, rc);
        check("R3 unimplemented reads zero", rd, 0);
        xfer(7'h7f, 2'd1, 0, rd, rc);
        check("R3 top address reads zero", rd, 0);
        xfer(7'h30, 2'd2, 32'h1234_5678, rd, rc);
        xfer(7'h03, 2'd2, 32'h1234_5678, rd, rc);
        xfer(7'h04, 2'd1, 0, rd, rc);
        check("R3 neighbour word untouched", rd, model[4]);
        xfer(7'h2f, 2'd1, 0, rd, rc);
        check("R3 neighbour word untouched", rd, model[47]);

        // R4 operation codes
        xfer(7'h05, 2'd0, 32'h5555_AAAA, rd, rc);
        check("R4 nop data", rd, 0);
        check("R4 nop code", {30'b0, rc}, 0);
        xfer(7'h05, 2'd3, 32'h5555_AAAA, rd, rc);
        check("R4 reserved op code", {30'b0, rc}, 2);
        xfer(7'h05, 2'd1, 0, rd, rc);
        check("R4 read code", {30'b0, rc}, 0);
        check("R4 nop/reserved no write", rd, model[5]);

        // R1 response held while rsp_ready low
        @(negedge clk);
        req_valid = 1'b1; req_addr = 7'h11; req_op = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_data;
        repeat (3) @(negedge clk);
        check("R1 held valid", {31'b0, rsp_valid}, 1);
        check("R1 ready low while pending", {31'b0, req_ready}, 0);
        check("R1 held data", rsp_data, rd);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R1 ready after take", {31'b0, req_ready}, 1);

        // R5/R6 control read-back with write-only bits set
        xfer(7'h10, 2'd2, ctrlw(1, 1, 1, 20'hABC12, 1, 1) | 32'h2400_0000, rd, rc);
        check("R6 ndm_reset output", {31'b0, ndm_reset}, 1);
        check("R6 dm_active output", {31'b0, dm_active}, 1);
        check("R7 nonexistent hart no halt", {28'b0, halt_req}, 0);
        check("R8 nonexistent hart no pulse", {28'b0, snap_res1}, 0);
        xfer(7'h10, 2'd1, 0, rd, rc);
        check("R5 control readback", rd, ctrlw(0, 0, 0, 20'hABC12, 1, 1));
        xfer(7'h11, 2'd1, 0, rd, rc);
        check("R12 nonexistent status", rd, exp_stat(99, 4'hF, 4'hF, 4'hF, 4'hF));

        // R7 halt levels
        xfer(7'h10, 2'd2, ctrlw(1, 0, 0, 20'd2, 0, 1), rd, rc);
        check("R7 halt hart2", {28'b0, halt_req}, 32'h4);
        xfer(7'h10, 2'd2, ctrlw(1, 0, 0, 20'd0, 0, 1), rd, rc);
        check("R7 halt hart0 keeps hart2", {28'b0, halt_req}, 32'h5);
        xfer(7'h10, 2'd2, ctrlw(0, 0, 0, 20'd2, 0, 1), rd, rc);
        check("R7 clear hart2", {28'b0, halt_req}, 32'h1);
        check("R6 ndm_reset cleared", {31'b0, ndm_reset}, 0);

        // R8 pulses
        xfer(7'h10, 2'd2, ctrlw(0, 1, 0, 20'd3, 0, 1), rd, rc);
        check("R8 resume pulse first cycle", {28'b0, snap_res1}, 32'h8);
        check("R8 resume pulse gone", {28'b0, snap_res2}, 0);
        check("R8 resume does not ack", {28'b0, snap_ack1}, 0);
        xfer(7'h10, 2'd2, ctrlw(0, 0, 1, 20'd1, 0, 1), rd, rc);
        check("R8 ack pulse first cycle", {28'b0, snap_ack1}, 32'h2);
        check("R8 ack pulse gone", {28'b0, snap_ack2}, 0);

        // R13 halt-on-reset bits ignored
        xfer(7'h10, 2'd2, ctrlw(0, 0, 0, 20'd1, 1, 1) | 32'h0000_000C, rd, rc);
        xfer(7'h10, 2'd1, 0, rd, rc);
        check("R13 control unchanged", rd, ctrlw(0, 0, 0, 20'd1, 1, 1));
        xfer(7'h11, 2'd1, 0, rd, rc);
        check("R13 status unchanged", rd, exp_stat(1, h_halt, h_run, h_ack, h_unav));

        // R9 deactivate
        xfer(7'h10, 2'd2, ctrlw(1, 0, 0, 20'd3, 1, 1), rd, rc);
        xfer(7'h10, 2'd2, ctrlw(1, 1, 1, 20'd2, 1, 0), rd, rc);
        check("R9 halt cleared", {28'b0, halt_req}, 0);
        check("R9 no pulse when inactive", {28'b0, snap_res1 | snap_ack1}, 0);
        check("R9 outputs cleared", {30'b0, ndm_reset, dm_active}, 0);
        xfer(7'h10, 2'd1, 0, rd, rc);
        check("R9 control reads zero", rd, 0);

        // R10/R11/R12 random status patterns
        for (int i = 0; i < 40; i++) begin
            int s = $urandom_range(0, NH + 1);
            xfer(7'h10, 2'd2, ctrlw(0, 0, 0, 20'(s), 0, 1), rd, rc);
            h_halt = 4'($urandom()); h_run = 4'($urandom());
            h_ack = 4'($urandom()); h_unav = 4'($urandom());
            xfer(7'h11, 2'd1, 0, rd, rc);
            if (s < NH) check("R11 status for hart", rd, exp_stat(s, h_halt, h_run, h_ack, h_unav));
            else check("R12 status no hart", rd, exp_stat(s, h_halt, h_run, h_ack, h_unav));
            check("R10 constant status fields", rd & 32'h004C_00FF, 32'h0000_0082);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule